// File: doc/BRIEF.md
# Low Pin Count Memory Read Target

This block sits on the peripheral side of a Low Pin Count bus and serves host memory read cycles from a byte-wide memory. It watches the frame strobe and the four-bit multiplexed bus on every rising clock edge. Once it sees a valid start nibble, it checks the cycle-type nibble and gathers a 32-bit address, sent most-significant nibble first. It then waits out the host's turnaround clock and takes the bus. It drives a ready sync code and returns the addressed byte as two nibbles, least-significant nibble first. Finally it drives all-ones for one clock and releases the bus.

The memory side is a simple synchronous read port. The address and a one-clock read strobe appear in the host's turnaround clock. The block latches the returned byte at the end of the following clock. The bus output is split into a value and an enable, which an outer tri-state buffer combines into the pad. A read with no interruption always takes 17 clocks, counted from the start clock. Clock 1 is the start and clock 17 is the final release.

Top module: `lpc_rd_target`

## Requirements
- R1: A cycle begins in a clock where `frame_n` is 0 and `lad_in` is 4'b0000. If `frame_n` stays low for several clocks, only the nibble of the last low clock decides. If that nibble is not 4'b0000, no response follows.
- R2: The nibble after the start is the cycle type. A memory read is accepted when bits 3:2 are 2'b01 and bit 1 is 0. Bit 0 has no effect, so 4'b0100 and 4'b0101 are both answered.
- R3: Clocks 3 to 10 carry the address, bits 31:28 first and bits 3:0 last. In clock 11 `mem_rd` is 1 for exactly that clock, and `mem_addr` holds the full 32-bit address.
- R4: During clocks 1 to 11 of a cycle, `lad_oe` is 0.
- R5: In clock 12, `lad_oe` is 1 and `lad_out` is 4'b1111.
- R6: In clock 13, `lad_oe` is 1 and `lad_out` is 4'b0000 (sync ready).
- R7: In clock 14 `lad_out` carries bits 3:0 of the byte, and in clock 15 it carries bits 7:4. The byte is the value on `mem_data` at the end of clock 12.
- R8: In clock 16, `lad_oe` is 1 and `lad_out` is 4'b1111. From clock 17 on, `lad_oe` is 0 until the next cycle reaches clock 12.
- R9: A cycle-type nibble that is not a memory read ends the cycle. `lad_oe` and `mem_rd` then stay 0 for the remainder of the 17 clocks.
- R10: If `frame_n` is 0 in any clock after the start, the current cycle is dropped and `lad_oe` is 0 from the next clock. The nibble of that clock is treated as a start field under R1.
- R11: While `rst_n` is 0 at a rising edge, the block returns to idle: `lad_oe` and `mem_rd` are 0 from the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all fields are sampled and launched on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Frame strobe from the host, active low |
| lad_in | input | 4 | Nibble seen on the shared bus |
| lad_out | output | 4 | Nibble the block presents when it owns the bus |
| lad_oe | output | 1 | Output enable for the bus pad buffer |
| mem_rd | output | 1 | One-clock read strobe to the memory |
| mem_addr | output | 32 | Read address to the memory |
| mem_data | input | 8 | Byte from the memory, valid one clock after the strobe |

## Verification
The assertions assume that the host keeps `frame_n` high from the cycle-type clock to the end of the response, unless it deliberately abandons the cycle. They also assume that the memory returns its byte one clock after the strobe. The bench keeps within this. It lowers `frame_n` only for start fields, for one deliberate abort in the data phase and for a held start. While the block drives the bus, the bench holds `lad_in` at all-ones, which models the pull-ups. Its memory model registers a byte computed from the address on the strobe edge. This meets the one-clock latency that the block relies on.

// File: rtl/lpc_rd_pkg.sv
package lpc_rd_pkg;

    // Bus phases seen from the target side; numbering follows the clock order
    typedef enum logic [3:0] {
        S_IDLE  = 4'd0,   // waiting for a start field
        S_TYPE  = 4'd1,   // cycle-type nibble expected
        S_ADDR  = 4'd2,   // address nibbles arriving
        S_HTAR  = 4'd3,   // host-owned turnaround clock
        S_TTAR  = 4'd4,   // target takes the bus
        S_SYNC  = 4'd5,   // ready code on the bus
        S_DATA  = 4'd6,   // data nibbles on the bus
        S_BTAR0 = 4'd7,   // target drives ones before release
        S_BTAR1 = 4'd8    // bus released back to the host
    } lpc_st_e;

    localparam logic [3:0] NIB_ZERO  = 4'b0000;
    localparam logic [3:0] NIB_ONES  = 4'b1111;
    localparam logic [3:0] TYPE_MASK = 4'b1110;
    localparam logic [3:0] TYPE_MRD  = 4'b0100;

endpackage

// File: rtl/lpc_rd_hdr_dec.sv
module lpc_rd_hdr_dec
    import lpc_rd_pkg::*;
(
    input  logic       frame_n,
    input  logic [3:0] lad,
    output logic       start_hit,
    output logic       rd_type
);

    // A start field is a zero nibble under an asserted frame strobe (R1)
    always_comb begin
        start_hit = !frame_n && (lad == NIB_ZERO);
    end

    // Memory read: bits 3:2 = 01, bit 1 = 0; bit 0 masked off (R2)
    always_comb begin
        rd_type = ((lad & TYPE_MASK) == TYPE_MRD);
    end

endmodule

// File: rtl/lpc_rd_addr_col.sv
module lpc_rd_addr_col #(
    parameter int ADDR_NIBS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   shift_en,
    input  logic [3:0]             nib,
    output logic [4*ADDR_NIBS-1:0] addr,
    output logic                   last
);

    localparam int ADDR_W = 4 * ADDR_NIBS;
    localparam int CNT_W  = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_NIBS - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
    } col_t;

    col_t q, d;

    // Most-significant nibble arrives first, so shift toward the top (R3)
    always_comb begin
        d = q;
        if (!shift_en) begin
            d.cnt = '0;
        end else begin
            d.addr = {q.addr[ADDR_W-5:0], nib};
            d.cnt  = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign addr = q.addr;
    assign last = shift_en && (q.cnt == CNT_LAST);

endmodule

// File: rtl/lpc_rd_ctrl.sv
module lpc_rd_ctrl
    import lpc_rd_pkg::*;
#(
    parameter int DATA_NIBS = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_n,
    input  logic                   start_hit,
    input  logic                   rd_type,
    input  logic                   addr_last,
    input  logic [4*DATA_NIBS-1:0] mem_data,
    output lpc_st_e                st,
    output logic                   lad_oe,
    output logic [3:0]             lad_out,
    output logic                   mem_rd
);

    localparam int DATA_W = 4 * DATA_NIBS;
    localparam int DCW    = (DATA_NIBS > 1) ? $clog2(DATA_NIBS) : 1;
    localparam logic [DCW-1:0] DCNT_LAST = DCW'(DATA_NIBS - 1);

    typedef struct packed {
        lpc_st_e           st;
        logic [DCW-1:0]    dcnt;
        logic [DATA_W-1:0] data;
        logic              oe;
        logic [3:0]        out;
        logic              rd;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{st: S_IDLE, dcnt: '0, data: '0,
                                   oe: 1'b0, out: NIB_ONES, rd: 1'b0};

    ctrl_t q, d;

    always_comb begin
        d    = q;
        d.rd = 1'b0;
        if (start_hit) begin
            // new start field wins over anything in flight (R1, R10)
            d.st   = S_TYPE;
            d.dcnt = '0;
        end else if (!frame_n) begin
            // frame strobe without a zero nibble drops the cycle (R10)
            d.st = S_IDLE;
        end else begin
            unique case (q.st)
                S_TYPE:  d.st = rd_type ? S_ADDR : S_IDLE;      // R2, R9
                S_ADDR: begin
                    if (addr_last) begin
                        d.st = S_HTAR;
                        d.rd = 1'b1;                            // R3
                    end
                end
                S_HTAR:  d.st = S_TTAR;
                S_TTAR: begin
                    d.st   = S_SYNC;
                    d.data = mem_data;                          // R7
                end
                S_SYNC: begin
                    d.st   = S_DATA;
                    d.dcnt = '0;
                end
                S_DATA: begin
                    if (q.dcnt == DCNT_LAST) begin
                        d.st = S_BTAR0;
                    end else begin
                        d.dcnt = q.dcnt + DCW'(1);
                    end
                end
                S_BTAR0: d.st = S_BTAR1;
                default: d.st = S_IDLE;
            endcase
        end

        // Pad controls are registered alongside the phase they belong to
        d.oe  = 1'b0;
        d.out = NIB_ONES;
        unique case (d.st)
            S_TTAR, S_BTAR0: begin
                d.oe  = 1'b1;
                d.out = NIB_ONES;                               // R5, R8
            end
            S_SYNC: begin
                d.oe  = 1'b1;
                d.out = NIB_ZERO;                               // R6
            end
            S_DATA: begin
                d.oe  = 1'b1;
                d.out = d.data[{d.dcnt, 2'b00} +: 4];           // low nibble first
            end
            default: begin
                d.oe  = 1'b0;
                d.out = NIB_ONES;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= CTRL_RST;
        end else begin
            q <= d;
        end
    end

    assign st      = q.st;
    assign lad_oe  = q.oe;
    assign lad_out = q.out;
    assign mem_rd  = q.rd;

endmodule

// File: rtl/lpc_rd_target.sv
module lpc_rd_target
    import lpc_rd_pkg::*;
#(
    parameter int ADDR_NIBS = 8,
    parameter int DATA_NIBS = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_n,
    input  logic [3:0]             lad_in,
    output logic [3:0]             lad_out,
    output logic                   lad_oe,
    output logic                   mem_rd,
    output logic [4*ADDR_NIBS-1:0] mem_addr,
    input  logic [4*DATA_NIBS-1:0] mem_data
);

    localparam int ADDR_W = 4 * ADDR_NIBS;

    logic              start_hit;
    logic              rd_type;
    logic              addr_last;
    logic              shift_en;
    logic [ADDR_W-1:0] addr;
    lpc_st_e           st;

    lpc_rd_hdr_dec u_hdr (
        .frame_n   (frame_n),
        .lad       (lad_in),
        .start_hit (start_hit),
        .rd_type   (rd_type)
    );

    assign shift_en = (st == S_ADDR) && frame_n;

    lpc_rd_addr_col #(
        .ADDR_NIBS (ADDR_NIBS)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .nib      (lad_in),
        .addr     (addr),
        .last     (addr_last)
    );

    lpc_rd_ctrl #(
        .DATA_NIBS (DATA_NIBS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .start_hit (start_hit),
        .rd_type   (rd_type),
        .addr_last (addr_last),
        .mem_data  (mem_data),
        .st        (st),
        .lad_oe    (lad_oe),
        .lad_out   (lad_out),
        .mem_rd    (mem_rd)
    );

    assign mem_addr = addr;

endmodule

// File: rtl/lpc_rd_target_chk.sv
module lpc_rd_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_n,
    input logic [3:0] lad_out,
    input logic       lad_oe,
    input logic       mem_rd
);

    // R4
    host_tar_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !lad_oe);

    // R5
    take_bus_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && frame_n) |=> (lad_oe && lad_out == 4'b1111));

    // R5
    enable_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lad_oe) |-> $past(mem_rd));

    // R6
    sync_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_rd) && lad_oe && frame_n) |=> (lad_oe && lad_out == 4'b0000));

    // R10
    abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lad_oe && !frame_n) |=> !lad_oe);

endmodule

bind lpc_rd_target lpc_rd_target_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_n (frame_n),
    .lad_out (lad_out),
    .lad_oe  (lad_oe),
    .mem_rd  (mem_rd)
);

// File: tb/tb_lpc_rd_target.sv
module tb_lpc_rd_target;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic [3:0]  lad_in = 4'hF;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic [7:0]  mem_q = 8'h00;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic        fr;
        logic [3:0]  nib;
        logic        eoe;
        logic [3:0]  eout;
        logic        erd;
        logic [31:0] eaddr;
        int          tag;
    } step_t;

    step_t plan[$];

    lpc_rd_target dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .lad_in   (lad_in),
        .lad_out  (lad_out),
        .lad_oe   (lad_oe),
        .mem_rd   (mem_rd),
        .mem_addr (mem_addr),
        .mem_data (mem_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h3C;
    endfunction

    // one-clock synchronous memory
    always @(posedge clk) begin
        if (mem_rd) mem_q <= mem_byte(mem_addr);
    end

    function automatic string tname(input int t);
        case (t)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; default: return "R11";
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input int t, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tname(t), what, act, exp);
        end
    endtask

    // Reference: expected target behaviour for each of the 17 clocks
    task automatic plan_read(input logic [31:0] a, input logic [3:0] ctype, input bit resp);
        logic [7:0] b;
        int         tq;
        b  = mem_byte(a);
        tq = resp ? 4 : 9;
        plan.delete();
        plan.push_back('{1'b0, 4'h0, 1'b0, 4'hF, 1'b0, 32'h0, tq});
        plan.push_back('{1'b1, ctype, 1'b0, 4'hF, 1'b0, 32'h0, tq});
        for (int i = 0; i < 8; i++)
            plan.push_back('{1'b1, a[31-4*i -: 4], 1'b0, 4'hF, 1'b0, 32'h0, tq});
        plan.push_back('{1'b1, 4'hF, 1'b0, 4'hF, resp, a, resp ? 3 : 9});
        plan.push_back('{1'b1, 4'hF, resp, 4'hF, 1'b0, 32'h0, resp ? 5 : 9});
        plan.push_back('{1'b1, 4'hF, resp, 4'h0, 1'b0, 32'h0, resp ? 6 : 9});
        plan.push_back('{1'b1, 4'hF, resp, b[3:0], 1'b0, 32'h0, resp ? 7 : 9});
        plan.push_back('{1'b1, 4'hF, resp, b[7:4], 1'b0, 32'h0, resp ? 7 : 9});
        plan.push_back('{1'b1, 4'hF, resp, 4'hF, 1'b0, 32'h0, resp ? 8 : 9});
        plan.push_back('{1'b1, 4'hF, 1'b0, 4'hF, 1'b0, 32'h0, resp ? 8 : 9});
    endtask

    task automatic plan_idle(input int n);
        plan.delete();
        for (int i = 0; i < n; i++)
            plan.push_back('{1'b1, 4'hF, 1'b0, 4'hF, 1'b0, 32'h0, 8});
    endtask

    // Drive at the falling edge, compare outputs launched by the last rising edge
    task automatic run_plan(input int n);
        for (int i = 0; i < n; i++) begin
            step_t s;
            s = plan[i];
            frame_n = s.fr;
            lad_in  = s.nib;
            chk({31'b0, lad_oe}, {31'b0, s.eoe}, s.tag, "lad_oe");
            if (s.eoe) chk({28'b0, lad_out}, {28'b0, s.eout}, s.tag, "lad_out");
            chk({31'b0, mem_rd}, {31'b0, s.erd}, s.tag, "mem_rd");
            if (s.erd) chk(mem_addr, s.eaddr, s.tag, "mem_addr");
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] old_b;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk({31'b0, lad_oe}, 32'h0, 11, "lad_oe in reset");
        chk({31'b0, mem_rd}, 32'h0, 11, "mem_rd in reset");
        rst_n = 1'b1;
        plan_idle(2); run_plan(2);

        // basic reads, R3 R5 R6 R7 R8
        plan_read(32'h1234_5678, 4'h4, 1'b1); run_plan(17);
        // R2: reserved bit 0 set still answered
        plan_read(32'hFEDC_BA98, 4'h5, 1'b1); plan[1].tag = 2; run_plan(17);
        plan_idle(2); run_plan(2);

        // R1: frame held low, last nibble zero counts
        plan_read(32'h0000_00A5, 4'h4, 1'b1);
        plan.push_front('{1'b0, 4'h0, 1'b0, 4'hF, 1'b0, 32'h0, 1});
        plan.push_front('{1'b0, 4'h7, 1'b0, 4'hF, 1'b0, 32'h0, 1});
        run_plan(19);

        // R1: zero then nonzero under low frame -> no response
        plan_read(32'h8000_0001, 4'h4, 1'b0);
        plan[0] = '{1'b0, 4'h9, 1'b0, 4'hF, 1'b0, 32'h0, 1};
        plan.push_front('{1'b0, 4'h0, 1'b0, 4'hF, 1'b0, 32'h0, 1});
        run_plan(18);

        // R9: write and non-memory types
        plan_read(32'h55AA_33CC, 4'h6, 1'b0); run_plan(17);
        plan_read(32'h0F0F_F0F0, 4'h0, 1'b0); run_plan(17);
        plan_read(32'h7777_1111, 4'hC, 1'b0); run_plan(17);

        // R10: abort in first data clock, new start in the same clock
        plan_read(32'hCAFE_0010, 4'h4, 1'b1); run_plan(13);
        old_b = mem_byte(32'hCAFE_0010);
        plan_read(32'h0BAD_F00D, 4'h4, 1'b1);
        plan[0].eoe  = 1'b1;
        plan[0].eout = old_b[3:0];
        plan[0].tag  = 10;
        plan[1].tag  = 10;
        run_plan(17);

        // back-to-back cycles without idle, R8
        plan_read(32'h0000_0000, 4'h4, 1'b1); run_plan(17);
        plan_read(32'hFFFF_FFFF, 4'h4, 1'b1); run_plan(17);

        // R11: reset in the middle of the data phase
        plan_read(32'h2468_ACE0, 4'h4, 1'b1); run_plan(14);
        rst_n   = 1'b0;
        frame_n = 1'b1;
        lad_in  = 4'hF;
        @(negedge clk);
        chk({31'b0, lad_oe}, 32'h0, 11, "lad_oe after mid-cycle reset");
        chk({31'b0, mem_rd}, 32'h0, 11, "mem_rd after mid-cycle reset");
        rst_n = 1'b1;
        plan_idle(2); run_plan(2);
        plan_read(32'h1357_9BDF, 4'h4, 1'b1); run_plan(17);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule